// File: doc/BRIEF.md
# Two-Step Subranging Flash Decoder

This block is the digital half of a 10-bit two-step flash converter that owns only one bank of sixteen comparators. A conversion first reads a coarse estimator: six comparators on a coarse divider give a thermometer word whose ones-count names one of seven regions. The decoder turns that region into the lowest tap of a 16-tap window on the 64-tap upper ladder. The window reaches 4 taps (1/16 of full scale) past the estimated region on each side. The shared bank is switched onto that window and its thermometer word gives the upper 6 bits. The bank is then switched onto the residue, which is the input minus the chosen upper tap, measured against sixteen 1-LSB steps. That second word gives the lower 4 bits.

One output bus, `tap_sel`, tells the analog multiplexer what to connect. In the coarse phase it carries the window base. In the fine phase (`fine_phase` high) it carries the chosen upper tap that is subtracted from the input. The 10-bit code is registered only once the fine word is decoded, and a one-cycle `done` pulse marks it.

Top module: `subrange_decoder`

## Requirements
- R1: Out of reset, `done` is 0, `result` is 0, `fine_phase` is 0 and `tap_sel` is 0.
- R2: A `start` seen high at a clock edge while idle runs the sequence estimate, coarse, fine, latch, one state per clock. `done` is high only in the latch cycle, which is the fourth cycle after the sampling edge, and it is low in the cycle that follows.
- R3: The estimator region is the number of ones in `est_therm`. During the coarse cycle, `fine_phase` is 0 and `tap_sel` equals 8 × region, clamped to at most 48, so the window never passes tap 63.
- R4: During the fine cycle, `fine_phase` is 1 and `tap_sel` is the upper code. That code is the window base plus the number of ones in the coarse `bank_therm` word, minus one. If the word has no ones, the code is the base.
- R5: The lower code is the number of ones in the fine `bank_therm` word, saturated at 15. In the latch cycle, `result` = upper code × 16 + lower code.
- R6: With ideal ladders, an estimator threshold that is off by less than 64 codes in either direction still gives `result` equal to the input code.
- R7: A single stray bit in an otherwise clean thermometer word moves the decoded value by exactly one, because decoding counts ones.
- R8: `start` is ignored while a conversion is under way. No new conversion begins from a `start` seen outside the idle state.
- R9: `result` holds its value in every cycle except the latch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion when idle |
| est_therm | input | 6 | Coarse estimator thermometer word |
| bank_therm | input | 16 | Shared comparator bank thermometer word |
| tap_sel | output | 6 | Window base (coarse phase) or subtracted upper tap (fine phase) |
| fine_phase | output | 1 | High while the bank is measuring the residue |
| result | output | 10 | Latched conversion code |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
A wrong region or window register appears on `tap_sel` in the coarse cycle, two cycles after start is sampled. It then shifts the upper code seen on `tap_sel` one cycle later. A bad upper-code register or a bad residue count first shows in `result` in the latch cycle. A sequencing fault shows as `done` arriving at the wrong cycle or lasting more than one cycle. The bench drives an ideal ladder model that reacts to `tap_sel`, so any selection error feeds back into the comparator words and the final code.

// File: rtl/subrange_pkg.sv
package subrange_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_EST    = 3'd1,
    ST_COARSE = 3'd2,
    ST_FINE   = 3'd3,
    ST_LATCH  = 3'd4
  } conv_state_t;

  // number of ones in the low n bits: bubble-tolerant thermometer decode
  function automatic int unsigned ones_of(input logic [63:0] w, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < 64; i++)
      if (i < n && w[i]) c++;
    return c;
  endfunction

  // window base from estimator region, clamped to the ladder
  function automatic int unsigned window_base(input int unsigned region,
                                              input int unsigned step,
                                              input int unsigned top);
    int unsigned lo;
    lo = region * step;
    if (lo > top) lo = top;
    return lo;
  endfunction

endpackage

// File: rtl/sr_sequencer.sv
module sr_sequencer
  import subrange_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output conv_state_t state,
  output logic        est_load,
  output logic        coarse_load,
  output logic        fine_load,
  output logic        done
);

  conv_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start) nxt = ST_EST;
      ST_EST:    nxt = ST_COARSE;
      ST_COARSE: nxt = ST_FINE;
      ST_FINE:   nxt = ST_LATCH;
      ST_LATCH:  nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;

  assign est_load    = (state == ST_EST);
  assign coarse_load = (state == ST_COARSE);
  assign fine_load   = (state == ST_FINE);
  assign done        = (state == ST_LATCH);

  // R2
  step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    est_load |=> coarse_load);

endmodule

// File: rtl/sr_coarse.sv
module sr_coarse
  import subrange_pkg::*;
#(
  parameter int MSB_W  = 6,
  parameter int EST_W  = 6,
  parameter int BANK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              est_load,
  input  logic              coarse_load,
  input  logic [EST_W-1:0]  est_therm,
  input  logic [BANK_W-1:0] bank_therm,
  output logic [MSB_W-1:0]  base,
  output logic [MSB_W-1:0]  msb
);

  localparam int TAPS = 1 << MSB_W;
  localparam int TOP  = TAPS - BANK_W;
  localparam int STEP = TAPS / (EST_W + 2);
  localparam int RW   = $clog2(EST_W + 1);

  logic [RW-1:0]    region_q;
  logic [MSB_W-1:0] msb_next;
  int unsigned      hits;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        region_q <= '0;
    else if (est_load) region_q <= RW'(ones_of(64'(est_therm), EST_W));

  assign base = MSB_W'(window_base(int'(region_q), STEP, TOP));

  always_comb begin
    hits = ones_of(64'(bank_therm), BANK_W);
    if (hits == 0) msb_next = base;
    else           msb_next = MSB_W'(int'(base) + int'(hits) - 1);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           msb <= '0;
    else if (coarse_load) msb <= msb_next;

  // R3
  window_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(base) <= TOP);

  // R4
  msb_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_load |=> (msb >= base) && (int'(msb) <= int'(base) + BANK_W - 1));

endmodule

// File: rtl/sr_fine.sv
module sr_fine
  import subrange_pkg::*;
#(
  parameter int MSB_W = 6,
  parameter int LSB_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fine_load,
  input  logic [(1<<LSB_W)-1:0]  bank_therm,
  input  logic [MSB_W-1:0]       msb,
  output logic [MSB_W+LSB_W-1:0] result
);

  localparam int BANK_W = 1 << LSB_W;
  localparam int LMAX   = BANK_W - 1;

  logic [LSB_W-1:0] lsb;
  int unsigned      hits;

  always_comb begin
    hits = ones_of(64'(bank_therm), BANK_W);
    lsb  = (hits > LMAX) ? LSB_W'(LMAX) : LSB_W'(hits);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         result <= '0;
    else if (fine_load) result <= {msb, lsb};

  // R5
  upper_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fine_load |=> result[MSB_W+LSB_W-1:LSB_W] == $past(msb));

endmodule

// File: rtl/subrange_decoder.sv
module subrange_decoder
  import subrange_pkg::*;
#(
  parameter int MSB_W = 6,
  parameter int LSB_W = 4,
  parameter int EST_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [EST_W-1:0]       est_therm,
  input  logic [(1<<LSB_W)-1:0]  bank_therm,
  output logic [MSB_W-1:0]       tap_sel,
  output logic                   fine_phase,
  output logic [MSB_W+LSB_W-1:0] result,
  output logic                   done
);

  localparam int BANK_W = 1 << LSB_W;

  conv_state_t      state;
  logic             est_load, coarse_load, fine_load;
  logic [MSB_W-1:0] base, msb;

  sr_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .state(state),
    .est_load(est_load), .coarse_load(coarse_load),
    .fine_load(fine_load), .done(done)
  );

  sr_coarse #(.MSB_W(MSB_W), .EST_W(EST_W), .BANK_W(BANK_W)) u_coarse (
    .clk(clk), .rst_n(rst_n), .est_load(est_load), .coarse_load(coarse_load),
    .est_therm(est_therm), .bank_therm(bank_therm), .base(base), .msb(msb)
  );

  sr_fine #(.MSB_W(MSB_W), .LSB_W(LSB_W)) u_fine (
    .clk(clk), .rst_n(rst_n), .fine_load(fine_load),
    .bank_therm(bank_therm), .msb(msb), .result(result)
  );

  always_comb begin
    if (coarse_load)    tap_sel = base;
    else if (fine_load) tap_sel = msb;
    else                tap_sel = '0;
  end
  assign fine_phase = fine_load;

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  fine_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fine_phase |=> done);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state != ST_IDLE) |=> state != ST_EST);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

endmodule

// File: tb/tb_subrange_decoder.sv
`timescale 1ns/1ps
module tb_subrange_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  est_therm;
  logic [15:0] bank_therm;
  logic [5:0]  tap_sel;
  logic        fine_phase;
  logic [9:0]  result;
  logic        done;

  int x = 0;
  int off [6];
  logic [15:0] bubble = '0;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  subrange_decoder dut (
    .clk(clk), .rst_n(rst_n), .start(start), .est_therm(est_therm),
    .bank_therm(bank_therm), .tap_sel(tap_sel), .fine_phase(fine_phase),
    .result(result), .done(done)
  );

  // ideal analog model: estimator thresholds at (2i+3)/16 of full scale plus error
  always_comb begin
    for (int i = 0; i < 6; i++) est_therm[i] = (x >= (2*i+3)*64 + off[i]);
  end

  // shared bank: coarse taps base+k, or residue steps k+1
  always_comb begin
    for (int k = 0; k < 16; k++) begin
      if (fine_phase) bank_therm[k] = (x - int'(tap_sel)*16 >= k+1);
      else            bank_therm[k] = (x >= (int'(tap_sel)+k)*16);
    end
    if (!fine_phase) bank_therm = bank_therm ^ bubble;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bench-side prediction of window base, upper code and final code
  task automatic predict(input int xv, input int bub, output int b, output int m, output int r);
    int reg_n, n, res;
    reg_n = 0;
    for (int i = 0; i < 6; i++) if (xv >= (2*i+3)*64 + off[i]) reg_n++;
    b = (8*reg_n > 48) ? 48 : 8*reg_n;
    n = 0;
    for (int k = 0; k < 16; k++) begin
      bit hit;
      hit = (xv >= (b+k)*16);
      if (k == bub) hit = !hit;
      if (hit) n++;
    end
    m = (n == 0) ? b : b + n - 1;
    res = xv - m*16;
    r = m*16 + ((res < 0) ? 0 : (res > 15) ? 15 : res);
  endtask

  task automatic convert(input int xv, input int bub, input bit hold_start, input bit exact);
    int b, m, r;
    x = xv;
    bubble = (bub < 0) ? 16'h0 : (16'h1 << bub);
    predict(xv, bub, b, m, r);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = hold_start;                 // estimate cycle
    chk(!done, "R2 early done", int'(done), 0);
    @(negedge clk);                                    // coarse cycle
    chk(tap_sel == 6'(b) && !fine_phase, "R3 window base", int'(tap_sel), b);
    @(negedge clk);                                    // fine cycle
    chk(tap_sel == 6'(m) && fine_phase, "R4 upper code", int'(tap_sel), m);
    start = 1'b0;
    @(negedge clk);                                    // latch cycle
    chk(done == 1'b1, "R2 done in latch cycle", int'(done), 1);
    chk(result == 10'(r), "R5 result", int'(result), r);
    if (exact) chk(result == 10'(xv), "R6 exact code", int'(result), xv);
    @(negedge clk);
    chk(!done && result == 10'(r), "R9 hold after pulse", int'(result), r);
    @(negedge clk);
    chk(!done && tap_sel == 6'd0 && !fine_phase, "R8 no restart", int'(tap_sel), 0);
    bubble = '0;
  endtask

  initial begin
    int e;
    void'($urandom(32'd7341));
    for (int i = 0; i < 6; i++) off[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && result == 10'd0 && tap_sel == 6'd0 && !fine_phase,
        "R1 reset state", int'(result), 0);

    // directed ends of the range (R3 clamp at top, R5 saturation)
    convert(0, -1, 1'b0, 1'b1);
    convert(1023, -1, 1'b0, 1'b1);
    convert(767, -1, 1'b0, 1'b1);
    convert(832, -1, 1'b0, 1'b1);

    // R6: estimator errors near 63 codes at region edges
    off[0] = -63; convert(3*64 - 63, -1, 1'b0, 1'b1);
    off[0] = 63;  convert(3*64 + 62, -1, 1'b0, 1'b1);
    off[0] = 0;
    off[5] = 63;  convert(13*64 + 62, -1, 1'b0, 1'b1);
    off[5] = -63; convert(13*64 - 63, -1, 1'b0, 1'b1);
    off[5] = 0;

    // R7: one stray bit above the ones run shifts the upper code by one
    convert(336, 12, 1'b0, 1'b0);
    chk(result == 10'd352, "R7 bubble shift", int'(result), 352);
    // R7: one missing bit inside the run shifts it down by one
    convert(336, 2, 1'b0, 1'b0);
    chk(result == 10'd335, "R7 bubble hole", int'(result), 335);

    // R8: start held high through a running conversion
    convert(517, -1, 1'b1, 1'b1);

    // random inputs with estimator errors under 64 codes (R6)
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < 6; i++) begin
        e = int'($urandom % 127) - 63;
        off[i] = e;
      end
      convert(int'($urandom % 1024), -1, 1'b0, 1'b1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule